// File: doc/BRIEF.md
# Underdesigned 8x8 Approximate Multiplier

This block multiplies two unsigned 8-bit operands and returns a 16-bit product that is deliberately inexact for some operand pairs. The arithmetic is built by recursive decomposition. Each operand is split into 2-bit digits. Every pair of digits goes to a small 2x2 cell that has only a 3-bit output. The cell is exact except when both digits are 3: it then returns 7 instead of 9, which saves its fourth output bit. Above the cell, all additions are exact. A 4x4 stage joins four cell results with shifts of 0, 2, 2 and 4 bits, and the 8x8 stage joins four 4x4 results with shifts of 0, 4, 4 and 8 bits.

The arithmetic is a single combinational cone. One output register follows it, so a product appears one clock after its operands are presented and a new pair can be accepted on every clock. Because each error term removes value and never adds it, the result can only fall below the exact product. This makes the block suited to error-tolerant datapaths, where a small and predictable loss buys a narrower partial-product array.

Top module: `udm_mul8`

## Requirements
- R1: With both operands below 4, the product is op_a*op_b, except that 3 times 3 gives 7.
- R2: The product equals the sum over digit positions i and j (0 to 3, with digit k being bits 2k+1 and 2k) of cell(a_i, b_j) shifted left by 2(i+j). Here cell(x,y) is 7 when x and y are both 3, and x*y otherwise.
- R3: The product never exceeds the exact product op_a*op_b.
- R4: If neither operand contains a 2-bit digit equal to 3, or if exactly one operand lacks such a digit, the product equals the exact product.
- R5: prod is registered. It shows the result for the operands sampled at the previous rising clock edge. While rst is high at a rising edge, prod is loaded with 0.
- R6: 255 times 255 gives 50575, where the exact product is 65025.
- R7: Across all 65536 operand pairs, exactly 30625 products differ from the exact product. These are the pairs in which both operands contain at least one digit equal to 3.
- R8: If either operand is 0, the product is 0, and bit 0 of the product always equals op_a[0] & op_b[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands are sampled and prod is updated on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears prod |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| prod | output | 16 | Registered approximate product |

## Verification
The main pattern is a sweep of every operand pair, one pair per clock, each compared against a digit-wise behavioural model. This sweep separates a faulty cell or a wrong shift amount from correct composition. The same sweep tallies how many products differ from the exact one, so it also catches an approximation that is triggered too often or too rarely. Small operands below 4 exercise the cell on its own. Pairs in which either operand lacks a digit equal to 3 must come out exact, which exposes errors leaking into cases the approximation should not touch. The all-ones pair and a reset applied mid-stream with non-zero operands pin down the largest error and the clearing of the output register.

// File: rtl/udm_pkg.sv
package udm_pkg;
  localparam int unsigned CELL_W    = 2;
  localparam int unsigned CELL_OUT  = 3;
  localparam logic [CELL_OUT-1:0] CELL_SAT = 3'b111;
endpackage

// File: rtl/udm_cell2.sv
module udm_cell2
  import udm_pkg::*;
(
  input  logic [CELL_W-1:0]   x,
  input  logic [CELL_W-1:0]   y,
  output logic [CELL_OUT-1:0] p
);
  // Exact 2x2 product, except 3*3 which collapses onto the 3-bit value 7.
  always_comb begin
    p[0] = x[0] & y[0];
    p[1] = (x[1] & y[0]) ^ (x[0] & y[1]);
    p[2] = x[1] & y[1];
    if (x == 2'b11 && y == 2'b11) p = CELL_SAT;
  end
endmodule

// File: rtl/udm_block.sv
module udm_block
  import udm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned PW = 2 * W;

  generate
    if (W == CELL_W) begin : g_leaf
      logic [CELL_OUT-1:0] c;
      udm_cell2 cell_i (.x(x), .y(y), .p(c));
      assign p = PW'(c);
    end else begin : g_split
      logic [W-1:0] pll, plh, phl, phh;
      udm_block #(.W(H)) ll_i (.x(x[H-1:0]), .y(y[H-1:0]), .p(pll));
      udm_block #(.W(H)) lh_i (.x(x[H-1:0]), .y(y[W-1:H]), .p(plh));
      udm_block #(.W(H)) hl_i (.x(x[W-1:H]), .y(y[H-1:0]), .p(phl));
      udm_block #(.W(H)) hh_i (.x(x[W-1:H]), .y(y[W-1:H]), .p(phh));
      // Exact shifted accumulation of the four sub-products.
      assign p = PW'(pll) + (PW'(plh) << H) + (PW'(phl) << H) + (PW'(phh) << W);
    end
  endgenerate
endmodule

// File: rtl/udm_mul8.sv
module udm_mul8 #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] prod_c;

  udm_block #(.W(W)) core_i (.x(op_a), .y(op_b), .p(prod_c));

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= prod_c;
  end
endmodule

// File: rtl/udm_mul8_chk.sv
module udm_mul8_chk #(
  parameter int unsigned W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [2*W-1:0] prod
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned ND = W / 2;

  function automatic logic has_three(input logic [W-1:0] v);
    logic r;
    r = 1'b0;
    for (int k = 0; k < ND; k++) if (v[2*k +: 2] == 2'b11) r = 1'b1;
    return r;
  endfunction

  logic          v_q, r_q, zero_q, lsb_q, clean_q;
  logic [PW-1:0] exact_q;

  always_ff @(posedge clk) begin
    r_q     <= rst;
    v_q     <= !rst;
    exact_q <= PW'(op_a) * PW'(op_b);
    zero_q  <= (op_a == '0) || (op_b == '0);
    lsb_q   <= op_a[0] & op_b[0];
    clean_q <= !has_three(op_a) || !has_three(op_b);
  end

  assert_never_over_R3: assert property (@(posedge clk) disable iff (rst)
    v_q |-> prod <= exact_q);
  assert_exact_clean_R4: assert property (@(posedge clk) disable iff (rst)
    (v_q && clean_q) |-> prod == exact_q);
  assert_zero_operand_R8: assert property (@(posedge clk) disable iff (rst)
    (v_q && zero_q) |-> prod == '0);
  assert_lsb_exact_R8: assert property (@(posedge clk) disable iff (rst)
    v_q |-> prod[0] == lsb_q);

  always_ff @(posedge clk) begin
    if (r_q) assert_reset_clears_R5: assert (prod == '0);
  end
endmodule

bind udm_mul8 udm_mul8_chk #(.W(W)) chk_i (.*);

// File: tb/udm_mul8_tb_top.sv
module udm_mul8_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic [15:0] prod;

  int checks = 0;
  int failures = 0;
  int errcnt = 0;
  bit done = 0;
  int unsigned expq[$];

  always #10 clk = ~clk;

  udm_mul8 #(.W(8)) dut_i (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod(prod));

  function automatic int unsigned model(int unsigned a, int unsigned b);
    int unsigned s = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        int unsigned da = (a >> (2*i)) & 3;
        int unsigned db = (b >> (2*j)) & 3;
        int unsigned c = (da == 3 && db == 3) ? 7 : da * db;
        s += c << (2*(i+j));
      end
    return s;
  endfunction

  function automatic bit any3(int unsigned v);
    for (int k = 0; k < 4; k++) if (((v >> (2*k)) & 3) == 3) return 1;
    return 0;
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, op_a, op_b, act, exp);
    end
  endtask

  // Drive at negedge, check one clock later at the next negedge.
  task automatic apply(int unsigned a, int unsigned b);
    int unsigned e, ex;
    op_a = 8'(a); op_b = 8'(b);
    expq.push_back(model(a, b));
    @(negedge clk);
    e  = expq.pop_front();
    ex = a * b;
    chk("R2", prod, e);
    checks++;
    if (prod > ex) begin
      failures++;
      $display("FAIL R3 a=%0d b=%0d actual=%0d expected<=%0d", a, b, prod, ex);
    end
    if (!any3(a) || !any3(b)) chk("R4", prod, ex);
    if (a < 4 && b < 4) chk("R1", prod, (a == 3 && b == 3) ? 7 : a * b);
    if (a == 0 || b == 0) chk("R8", prod, 0);
    chk("R8", prod & 1, a & b & 1);
    if (prod != ex) errcnt++;
  endtask

  initial begin
    op_a = 8'hA5; op_b = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R5", prod, 0);
    rst = 1'b0;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) apply(a, b);
    chk("R7", errcnt, 30625);
    apply(255, 255);
    chk("R6", prod, 50575);
    apply(3, 3);
    chk("R6", prod, 7);
    op_a = 8'hFF; op_b = 8'hFF; rst = 1'b1;
    @(negedge clk);
    chk("R5", prod, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R5", prod, 50575);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule